// File: doc/BRIEF.md
# Unsigned Subtractor with Sign and Magnitude Result

This combinational block takes two unsigned operands of equal width, a minuend and a subtrahend, and produces their true difference as a negative flag plus a magnitude of the same width. It has no dedicated subtraction logic. It uses a bitwise conditional inverter and a ripple-carry adder built from half adders. A second pass through the same two building blocks turns the wrapped sum back into a magnitude.

A single mode input selects how the subtrahend is complemented. In radix-complement mode the inverted subtrahend is added with a carry-in of one. In diminished-radix mode it is added with no carry-in, and an end carry is folded back into the least significant bit. Either way the final magnitude and sign are the same. The raw end carry of the first addition is also brought out, because it is the comparison result that the correction stage acts on.

Top module: `submag_unit`

## Requirements
- R1: The operand width `WIDTH` is a parameter with a default of 8. All outputs are combinational functions of the current inputs, with no storage.
- R2: With `cpl_mode` = 0 (radix-complement), `end_carry` is 1 exactly when `minuend` >= `subtrahend`.
- R3: When `minuend` >= `subtrahend`, `neg` is 0 and `magnitude` equals `minuend - subtrahend`.
- R4: When `minuend` < `subtrahend`, `neg` is 1 and `magnitude` equals `subtrahend - minuend`, in either mode.
- R5: With `cpl_mode` = 1 (diminished-radix), `end_carry` is 1 exactly when `minuend` > `subtrahend`. In that case the end-around carry makes the result positive with `magnitude` = `minuend - subtrahend`.
- R6: Equal operands give `magnitude` = 0 and `neg` = 0 in both modes. `end_carry` is then 1 in mode 0 and 0 in mode 1.
- R7: `magnitude` and `neg` never depend on `cpl_mode`. Only `end_carry` may differ between the two modes.
- R8: At the range limits, the all-ones minuend with a zero subtrahend gives magnitude 2^WIDTH-1 positive. The reverse gives magnitude 2^WIDTH-1 negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| minuend | input | WIDTH | Unsigned operand M |
| subtrahend | input | WIDTH | Unsigned operand N, subtracted from M |
| cpl_mode | input | 1 | 0: radix-complement, 1: diminished-radix with end-around carry |
| magnitude | output | WIDTH | Absolute value of M - N |
| neg | output | 1 | 1 when M < N |
| end_carry | output | 1 | Carry out of the first addition |

## Verification
A fault in the complementer or in the first adder's carry chain shows at once as a wrong `end_carry`. That error then spreads into both `neg` and `magnitude`, because the correction stage is steered by that carry. A wrong carry-in choice in the correction stage shows up as a magnitude that is off by exactly one, and only in one mode. For that reason every operand pair is checked in both modes, and equal operands are covered separately. Since the block holds no state, any fault is visible in the same evaluation as the inputs that expose it.

// File: rtl/submag_pkg.sv
package submag_pkg;
   typedef enum logic {
      CPL_RADIX      = 1'b0,
      CPL_DIMINISHED = 1'b1
   } cpl_mode_e;
endpackage

// File: rtl/submag_cond_inv.sv
module submag_cond_inv #(
   parameter int W = 8
) (
   input  logic [W-1:0] din,
   input  logic         invert,
   output logic [W-1:0] dout
);
   initial begin
      assert (W >= 1) else $error("submag_cond_inv: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign dout[i] = din[i] ^ invert;
   end
endmodule

// File: rtl/submag_half_add.sv
module submag_half_add (
   input  logic a,
   input  logic b,
   output logic s,
   output logic c
);
   assign s = a ^ b;
   assign c = a & b;
endmodule

// File: rtl/submag_ripple_add.sv
module submag_ripple_add #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   localparam int CW = W + 1;

   logic [CW-1:0] chain;
   assign chain[0] = cin;

   initial begin
      assert (W >= 1) else $error("submag_ripple_add: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_fa
      logic p_s, p_c, q_c;
      submag_half_add u_ha0 (.a(a[i]), .b(b[i]),     .s(p_s),    .c(p_c));
      submag_half_add u_ha1 (.a(p_s),  .b(chain[i]), .s(sum[i]), .c(q_c));
      assign chain[i+1] = p_c | q_c;
   end

   assign cout = chain[W];

   // The ripple chain must agree with plain integer addition (R2 / R5 carry basis).
   always_comb begin
      assert_chain_exact_R2: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
         else $error("ripple adder disagrees with arithmetic sum");
   end
endmodule

// File: rtl/submag_unit.sv
module submag_unit #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] minuend,
   input  logic [WIDTH-1:0] subtrahend,
   input  logic             cpl_mode,
   output logic [WIDTH-1:0] magnitude,
   output logic             neg,
   output logic             end_carry
);
   import submag_pkg::*;

   localparam int XW = WIDTH + 1;

   initial begin
      assert (WIDTH >= 2) else $error("submag_unit: WIDTH must be at least 2");
   end

   cpl_mode_e mode;
   assign mode = cpl_mode_e'(cpl_mode);

   // Stage 1: invert the subtrahend, add, and take the end carry.
   logic [WIDTH-1:0] sub_inv;
   logic [WIDTH-1:0] raw_sum;
   logic             raw_carry;
   logic             cin_first;

   assign cin_first = (mode == CPL_RADIX);

   submag_cond_inv #(.W(WIDTH)) u_inv_sub (
      .din(subtrahend), .invert(1'b1), .dout(sub_inv)
   );

   submag_ripple_add #(.W(WIDTH)) u_add_first (
      .a(minuend), .b(sub_inv), .cin(cin_first), .sum(raw_sum), .cout(raw_carry)
   );

   // Stage 2: re-complement when there was no carry, or add the end-around carry.
   logic [WIDTH-1:0] fix_in;
   logic [WIDTH-1:0] fix_sum;
   logic             fix_cout;
   logic             cin_fix;

   submag_cond_inv #(.W(WIDTH)) u_inv_fix (
      .din(raw_sum), .invert(~raw_carry), .dout(fix_in)
   );

   always_comb begin
      if (mode == CPL_RADIX) cin_fix = ~raw_carry;
      else                   cin_fix = raw_carry;
   end

   submag_ripple_add #(.W(WIDTH)) u_add_fix (
      .a(fix_in), .b({WIDTH{1'b0}}), .cin(cin_fix), .sum(fix_sum), .cout(fix_cout)
   );

   logic fix_cout_unused;
   assign fix_cout_unused = fix_cout;

   assign magnitude = fix_sum;
   assign end_carry = raw_carry;
   // In diminished-radix mode, equal operands give an all-ones sum with no carry.
   // That is a zero, so the sign is qualified by a nonzero magnitude.
   assign neg       = ~raw_carry & (|fix_sum);

   logic signed [XW:0] diff_ref;
   assign diff_ref = $signed({2'b00, minuend}) - $signed({2'b00, subtrahend});

   always_comb begin
      if (minuend >= subtrahend) begin
         assert_pos_result_R3: assert (!neg && magnitude == WIDTH'(diff_ref))
            else $error("positive difference wrong");
      end else begin
         assert_neg_result_R4: assert (neg && magnitude == WIDTH'(-diff_ref))
            else $error("negative difference wrong");
      end
      if (mode == CPL_RADIX) begin
         assert_carry_radix_R2: assert (end_carry == (minuend >= subtrahend))
            else $error("radix end carry wrong");
      end else begin
         assert_carry_dimin_R5: assert (end_carry == (minuend > subtrahend))
            else $error("diminished end carry wrong");
      end
      assert_zero_unsigned_R6: assert (!(neg && magnitude == '0))
         else $error("negative zero produced");
   end
endmodule

// File: tb/tb_submag_unit.sv
module tb_submag_unit;
   localparam int W = 8;
   localparam int MAXV = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [W-1:0] m_in, n_in;
   logic         mode_in;
   logic [W-1:0] mag;
   logic         neg_o, carry_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   submag_unit #(.WIDTH(W)) dut (
      .minuend(m_in), .subtrahend(n_in), .cpl_mode(mode_in),
      .magnitude(mag), .neg(neg_o), .end_carry(carry_o)
   );

   task automatic check(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (m=%0d n=%0d mode=%0d)",
                  req, what, got, exp, m_in, n_in, mode_in);
      end
   endtask

   // Apply inputs away from the clock edge, wait for them to settle, and compare
   // against values computed here from the requirements.
   task automatic apply_and_check(input int m, input int n, input bit md, input string req);
      int exp_mag;
      bit exp_neg;
      bit exp_cy;
      @(negedge clk);
      m_in = W'(m); n_in = W'(n); mode_in = md;
      #1;
      exp_neg = (m < n);
      exp_mag = exp_neg ? (n - m) : (m - n);
      exp_cy  = md ? (m > n) : (m >= n);
      check(req, "magnitude", int'(mag), exp_mag);
      check(req, "neg", int'(neg_o), int'(exp_neg));
      check(md ? "R5" : "R2", "end_carry", int'(carry_o), int'(exp_cy));
   endtask

   task automatic t_idle_state();
      // R1: combinational, with zero inputs the outputs settle at once
      apply_and_check(0, 0, 1'b0, "R1");
   endtask

   task automatic t_positive();
      apply_and_check(84, 67, 1'b0, "R3");
      apply_and_check(200, 13, 1'b0, "R3");
      apply_and_check(84, 67, 1'b1, "R5");
      apply_and_check(5, 1, 1'b1, "R5");
   endtask

   task automatic t_negative();
      apply_and_check(67, 84, 1'b0, "R4");
      apply_and_check(19, 30, 1'b0, "R4");
      apply_and_check(5, 6, 1'b1, "R4");
      apply_and_check(3, 250, 1'b1, "R4");
   endtask

   task automatic t_equal();
      for (int v = 0; v <= MAXV; v += 51) begin
         apply_and_check(v, v, 1'b0, "R6");
         apply_and_check(v, v, 1'b1, "R6");
      end
   endtask

   task automatic t_limits();
      apply_and_check(MAXV, 0, 1'b0, "R8");
      apply_and_check(MAXV, 0, 1'b1, "R8");
      apply_and_check(0, MAXV, 1'b0, "R8");
      apply_and_check(0, MAXV, 1'b1, "R8");
   endtask

   task automatic t_mode_independence();
      for (int m = 0; m <= MAXV; m += 7) begin
         for (int n = 0; n <= MAXV; n += 5) begin
            logic [W-1:0] mag_a;
            logic         neg_a;
            apply_and_check(m, n, 1'b0, "R7");
            mag_a = mag; neg_a = neg_o;
            apply_and_check(m, n, 1'b1, "R7");
            check("R7", "magnitude across modes", int'(mag), int'(mag_a));
            check("R7", "neg across modes", int'(neg_o), int'(neg_a));
         end
      end
   endtask

   initial begin
      m_in = '0; n_in = '0; mode_in = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle_state();
      t_positive();
      t_negative();
      t_equal();
      t_limits();
      t_mode_independence();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #1500000;
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule